// File: doc/BRIEF.md
# PCM Highway Transmit Slot Assigner

This block places the transmit data of one voice channel onto a time-division PCM highway. It runs on the highway bit clock. A frame sync pulse marks bit 0 of slot 0. The block counts bit positions from that pulse. When the count reaches the programmed slot, plus a sub-slot offset of 0 to 7 bit clocks, it shifts out either an 8-bit companded byte, a 16-bit linear word over two consecutive slots, or a companded byte followed by a signaling byte.

Either of two serial data ports can carry the data, or both at once. Each port has an active-low strobe that is low while the port is driving, and the data line is released to high impedance at all other times. A configuration bit chooses which bit-clock edge launches data and strobes. The sample inputs are captured at frame sync, so any update made part-way through a frame cannot tear the word being sent.

Top module: `pcm_tx_slotter`

## Requirements
- R1: While `rst` is high and until the first frame sync, both strobes are high.
- R2: A frame sync sampled high on a rising edge makes that clock the frame's bit 0. The assigned slot starts at bit position `tx_slot*8 + clk_slot`, and `tx_slot` can be any value from 0 to 127.
- R3: Words go out most significant bit first.
- R4: With `lin_mode=0` and `sig_mode=0`, the 8 bits of `comp_sample` are sent in one slot, and the strobe is low for exactly 8 bit clocks.
- R5: With `lin_mode=1`, the 16 bits of `lin_sample` are sent over two consecutive slots, and the strobe is low for 16 bit clocks.
- R6: With `sig_mode=1` and `lin_mode=0`, `comp_sample` goes out first and is followed at once by `sig_byte`, giving 16 bits in all.
- R7: When `lin_mode` and `sig_mode` are both 1, the linear format is used.
- R8: `port_en[0]` routes data to `dxa`/`tsca_n` and `port_en[1]` routes data to `dxb`/`tscb_n`. A disabled port keeps its strobe high. When both ports are enabled they carry identical data and strobes.
- R9: With `fall_launch=0`, outputs change just after the rising edge. With `fall_launch=1`, the same values appear half a bit clock later, on the falling edge.
- R10: The samples sent in a frame are the values present on the clock where frame sync is sampled. Later changes within that frame do not appear on the ports.
- R11: `clk_slot` delays the start of the slot by 0 to 7 bit clocks, and each offset shifts the whole burst by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, one clock high at bit 0 of slot 0 |
| tx_slot | input | 7 | Assigned time slot |
| clk_slot | input | 3 | Sub-slot offset in bit clocks |
| lin_mode | input | 1 | 16-bit linear format |
| sig_mode | input | 1 | Companded byte plus signaling byte |
| port_en | input | 2 | Bit 0 enables port A, bit 1 enables port B |
| fall_launch | input | 1 | 1 launches outputs on the falling edge |
| comp_sample | input | 8 | Companded sample |
| lin_sample | input | 16 | Linear sample |
| sig_byte | input | 8 | Signaling byte |
| dxa | output | 1 | Serial data, port A (high-Z when idle) |
| dxb | output | 1 | Serial data, port B (high-Z when idle) |
| tsca_n | output | 1 | Port A strobe, low while driving |
| tscb_n | output | 1 | Port B strobe, low while driving |

## Verification
Each rising edge's position and data bit are registered in that edge. With rising launch they are visible in the same clock period. With falling launch they appear only after the next falling edge. The reference model computes one expected value per rising edge and checks the ports twice in each period. The early check, 2 ns after the rising edge, compares against the current value for rising launch and the previous one for falling launch. The late check, 6 ns after the edge (past the falling edge), compares against the current value in both modes. This separates the two launch edges by exactly half a bit clock.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic [1:0] {
    FMT_COMP = 2'd0,
    FMT_SIG  = 2'd1,
    FMT_LIN  = 2'd2
  } word_fmt_e;

  // linear wins when both format bits are set
  function automatic word_fmt_e pick_fmt(input logic lin, input logic sig);
    if (lin)      return FMT_LIN;
    else if (sig) return FMT_SIG;
    else          return FMT_COMP;
  endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
module pcm_frame_counter #(
  parameter int POS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0] cnt_q;

  // position of the bit launched at this edge; saturates without a sync
  always_comb begin
    if (fsync)                pos = '0;
    else if (cnt_q == POS_MAX) pos = POS_MAX;
    else                      pos = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= POS_MAX;
    else     cnt_q <= pos;
  end
endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window
  import pcm_tx_pkg::*;
#(
  parameter int SLOT_W  = 7,
  parameter int CSLOT_W = 3,
  parameter int BYTE_W  = 8,
  parameter int POS_W   = 11,
  parameter int OFF_W   = 4
) (
  input  logic [POS_W-1:0]   pos,
  input  logic [SLOT_W-1:0]  tslot,
  input  logic [CSLOT_W-1:0] cslot,
  input  word_fmt_e          fmt,
  output logic               active,
  output logic [OFF_W-1:0]   msb_off
);
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam logic [POS_W-1:0] LEN_ONE = POS_W'(BYTE_W);
  localparam logic [POS_W-1:0] LEN_TWO = POS_W'(2 * BYTE_W);

  logic [POS_W-1:0] start_pos;
  logic [POS_W-1:0] off;
  logic [POS_W-1:0] len;

  always_comb begin
    start_pos = (POS_W'(tslot) << BIT_IDX_W) + POS_W'(cslot);
    off       = pos - start_pos;
    len       = (fmt == FMT_COMP) ? LEN_ONE : LEN_TWO;
    active    = (pos >= start_pos) && (off < len);
    msb_off   = off[OFF_W-1:0];
  end
endmodule

// File: rtl/pcm_word_serializer.sv
module pcm_word_serializer
  import pcm_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fsync,
  input  logic [BYTE_W-1:0]   comp_in,
  input  logic [2*BYTE_W-1:0] lin_in,
  input  logic [BYTE_W-1:0]   sig_in,
  input  word_fmt_e           fmt,
  input  logic [OFF_W-1:0]    msb_off,
  output logic                bit_out
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] comp_q, sig_q;
  logic [WORD_W-1:0] lin_q;
  logic [BYTE_W-1:0] comp_c, sig_c;
  logic [WORD_W-1:0] lin_c, word;

  always_ff @(posedge clk) begin
    if (rst) begin
      comp_q <= '0;
      sig_q  <= '0;
      lin_q  <= '0;
    end else if (fsync) begin
      comp_q <= comp_in;
      sig_q  <= sig_in;
      lin_q  <= lin_in;
    end
  end

  // at the sync edge itself the fresh sample is already in use
  always_comb begin
    comp_c  = fsync ? comp_in : comp_q;
    sig_c   = fsync ? sig_in  : sig_q;
    lin_c   = fsync ? lin_in  : lin_q;
    word    = (fmt == FMT_LIN) ? lin_c : {comp_c, sig_c};
    bit_out = word[WORD_W - 1 - int'(msb_off)];
  end
endmodule

// File: rtl/pcm_launch_stage.sv
module pcm_launch_stage (
  input  logic clk,
  input  logic rst,
  input  logic fall_launch,
  input  logic d_in,
  input  logic drive_in,
  output logic d_out,
  output logic drive_out
);
  logic d_r, drive_r, d_f, drive_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_r     <= 1'b0;
      drive_r <= 1'b0;
    end else begin
      d_r     <= d_in;
      drive_r <= drive_in;
    end
  end

  // half-cycle retimed copy for falling-edge launch
  always_ff @(negedge clk) begin
    if (rst) begin
      d_f     <= 1'b0;
      drive_f <= 1'b0;
    end else begin
      d_f     <= d_r;
      drive_f <= drive_r;
    end
  end

  assign d_out     = fall_launch ? d_f     : d_r;
  assign drive_out = fall_launch ? drive_f : drive_r;
endmodule

// File: rtl/pcm_tx_slotter.sv
module pcm_tx_slotter
  import pcm_tx_pkg::*;
#(
  parameter int SLOT_W  = 7,
  parameter int CSLOT_W = 3,
  parameter int BYTE_W  = 8,
  parameter int NPORT   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fsync,
  input  logic [SLOT_W-1:0]   tx_slot,
  input  logic [CSLOT_W-1:0]  clk_slot,
  input  logic                lin_mode,
  input  logic                sig_mode,
  input  logic [NPORT-1:0]    port_en,
  input  logic                fall_launch,
  input  logic [BYTE_W-1:0]   comp_sample,
  input  logic [2*BYTE_W-1:0] lin_sample,
  input  logic [BYTE_W-1:0]   sig_byte,
  output logic                dxa,
  output logic                dxb,
  output logic                tsca_n,
  output logic                tscb_n
);
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int POS_W     = SLOT_W + BIT_IDX_W + 1;
  localparam int OFF_W     = $clog2(2 * BYTE_W);

  logic [POS_W-1:0] pos;
  logic [OFF_W-1:0] msb_off;
  logic             in_slot, tx_bit;
  word_fmt_e        fmt;
  logic [NPORT-1:0] p_data, p_drive;

  assign fmt = pick_fmt(lin_mode, sig_mode);

  pcm_frame_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst(rst), .fsync(fsync), .pos(pos)
  );

  pcm_slot_window #(
    .SLOT_W(SLOT_W), .CSLOT_W(CSLOT_W), .BYTE_W(BYTE_W),
    .POS_W(POS_W), .OFF_W(OFF_W)
  ) u_win (
    .pos(pos), .tslot(tx_slot), .cslot(clk_slot), .fmt(fmt),
    .active(in_slot), .msb_off(msb_off)
  );

  pcm_word_serializer #(.BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_ser (
    .clk(clk), .rst(rst), .fsync(fsync),
    .comp_in(comp_sample), .lin_in(lin_sample), .sig_in(sig_byte),
    .fmt(fmt), .msb_off(msb_off), .bit_out(tx_bit)
  );

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    pcm_launch_stage u_launch (
      .clk(clk), .rst(rst), .fall_launch(fall_launch),
      .d_in(tx_bit), .drive_in(in_slot && port_en[gi]),
      .d_out(p_data[gi]), .drive_out(p_drive[gi])
    );
  end

  assign dxa    = p_drive[0] ? p_data[0] : 1'bz;
  assign dxb    = p_drive[1] ? p_data[1] : 1'bz;
  assign tsca_n = ~p_drive[0];
  assign tscb_n = ~p_drive[1];
endmodule

// File: rtl/pcm_tx_slotter_chk.sv
module pcm_tx_slotter_chk #(
  parameter int NPORT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] port_en,
  input logic             tsca_n,
  input logic             tscb_n,
  input logic [NPORT-1:0] p_data
);
  logic [5:0] run_a;

  always_ff @(posedge clk) begin
    if (rst)         run_a <= '0;
    else if (!tsca_n) run_a <= (run_a == 6'd63) ? run_a : run_a + 1'b1;
    else             run_a <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tsca_n && tscb_n));

  // R8
  port_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!port_en[0] && $past(!port_en[0]) && $past(!port_en[0], 2)) |-> tsca_n);

  // R8
  dual_match_chk: assert property (@(posedge clk) disable iff (rst)
    ((port_en == 2'b11) && $past(port_en == 2'b11) && $past(port_en == 2'b11, 2))
      |-> (tsca_n == tscb_n) && (tsca_n || (p_data[0] == p_data[1])));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    run_a <= 6'd16);
endmodule

bind pcm_tx_slotter pcm_tx_slotter_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst(rst), .port_en(port_en),
  .tsca_n(tsca_n), .tscb_n(tscb_n), .p_data(p_data)
);

// File: tb/tb_pcm_tx_slotter.sv
`timescale 1ns/1ps
module tb_pcm_tx_slotter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0;
  logic [6:0]  tx_slot = '0;
  logic [2:0]  clk_slot = '0;
  logic        lin_mode = 1'b0, sig_mode = 1'b0;
  logic [1:0]  port_en = 2'b00;
  logic        fall_launch = 1'b0;
  logic [7:0]  comp_sample = '0, sig_byte = '0;
  logic [15:0] lin_sample = '0;
  wire         dxa, dxb, tsca_n, tscb_n;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  pcm_tx_slotter dut (
    .clk(clk), .rst(rst), .fsync(fsync), .tx_slot(tx_slot), .clk_slot(clk_slot),
    .lin_mode(lin_mode), .sig_mode(sig_mode), .port_en(port_en),
    .fall_launch(fall_launch), .comp_sample(comp_sample), .lin_sample(lin_sample),
    .sig_byte(sig_byte), .dxa(dxa), .dxb(dxb), .tsca_n(tsca_n), .tscb_n(tscb_n)
  );

  always #4 clk = ~clk;

  // reference model state
  int   pos = 100000;
  logic [15:0] lin_q = '0;
  logic [7:0]  comp_q = '0, sig_q = '0;
  bit   cur_sa = 1, cur_sb = 1, cur_d = 0;
  bit   prv_sa = 1, prv_sb = 1, prv_d = 0;

  task automatic check_now(input bit sa, input bit sb, input bit d, input string when);
    checks++;
    if (tsca_n !== sa) begin
      fails++;
      $display("FAIL %s %s tsca_n actual=%b expected=%b t=%0t", tag, when, tsca_n, sa, $time);
    end
    checks++;
    if (tscb_n !== sb) begin
      fails++;
      $display("FAIL %s %s tscb_n actual=%b expected=%b t=%0t", tag, when, tscb_n, sb, $time);
    end
    if (!sa) begin
      checks++;
      if (dxa !== d) begin
        fails++;
        $display("FAIL %s %s dxa actual=%b expected=%b t=%0t", tag, when, dxa, d, $time);
      end
    end
    if (!sb) begin
      checks++;
      if (dxb !== d) begin
        fails++;
        $display("FAIL %s %s dxb actual=%b expected=%b t=%0t", tag, when, dxb, d, $time);
      end
    end
  endtask

  always @(posedge clk) begin
    int start, len, off;
    bit act;
    logic [15:0] word;
    prv_sa = cur_sa; prv_sb = cur_sb; prv_d = cur_d;
    if (rst) pos = 100000;
    else if (fsync) begin
      pos = 0; lin_q = lin_sample; comp_q = comp_sample; sig_q = sig_byte;
    end else if (pos < 100000) pos++;
    start = int'(tx_slot) * 8 + int'(clk_slot);
    len   = (lin_mode || sig_mode) ? 16 : 8;     // R7: linear wins
    word  = lin_mode ? lin_q : {comp_q, sig_q};  // R6 byte order
    off   = pos - start;
    act   = !rst && pos >= start && off < len;
    cur_d  = act ? word[15 - off] : 1'b0;        // R3 MSB first
    cur_sa = !(act && port_en[0]);
    cur_sb = !(act && port_en[1]);
    if (!done) begin
      #2;
      // R9: falling launch lags half a clock
      if (fall_launch) check_now(prv_sa, prv_sb, prv_d, "early");
      else             check_now(cur_sa, cur_sb, cur_d, "early");
      #4;
      check_now(cur_sa, cur_sb, cur_d, "late");
    end
  end

  task automatic run_phase(input string t, input int ts, input int cs,
                           input bit lin, input bit sig, input logic [1:0] en,
                           input bit fall, input int frames, input int flen);
    @(negedge clk);
    tag = t; tx_slot = 7'(ts); clk_slot = 3'(cs); lin_mode = lin; sig_mode = sig;
    port_en = en; fall_launch = fall;
    for (int f = 0; f < frames; f++) begin
      for (int b = 0; b < flen; b++) begin
        fsync = (b == 0);
        // R10: samples move every clock; only the sync-time value may appear
        comp_sample = 8'($urandom);
        sig_byte    = 8'($urandom);
        lin_sample  = 16'($urandom);
        @(negedge clk);
      end
    end
    fsync = 1'b0;
  endtask

  initial begin
    repeat (6) @(negedge clk);               // R1 reset idle
    rst = 1'b0;
    repeat (4) @(negedge clk);               // R1 idle before first sync
    run_phase("R4", 3, 0, 0, 0, 2'b01, 0, 3, 256);
    run_phase("R2", 0, 0, 0, 0, 2'b01, 0, 2, 256);
    run_phase("R11", 2, 5, 0, 0, 2'b01, 0, 3, 256);
    run_phase("R5", 5, 2, 1, 0, 2'b11, 0, 3, 256);
    run_phase("R6", 1, 7, 0, 1, 2'b10, 0, 3, 256);
    run_phase("R7", 4, 3, 1, 1, 2'b01, 0, 3, 256);
    run_phase("R9", 6, 1, 0, 1, 2'b11, 1, 3, 256);
    run_phase("R10", 9, 4, 1, 0, 2'b01, 1, 3, 256);
    run_phase("R8", 2, 0, 0, 0, 2'b00, 0, 2, 256);
    run_phase("R8", 2, 0, 0, 0, 2'b10, 0, 2, 256);
    run_phase("R3", 127, 0, 0, 0, 2'b11, 0, 2, 1024);
    repeat (4) @(negedge clk);
    done = 1;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 8);
    fails++;
    $display("FAIL watchdog expired in %s", tag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule